// File: doc/BRIEF.md
# Host Packet Window Pointer

This block sits between a host's I/O-mapped data port and a paged packet buffer. The host first loads a pointer register that holds a byte offset into a packet, a bit that picks which packet is meant, and an auto-advance enable. It then reads or writes through a data port. Each data access is turned into a physical buffer address. The offset is split into a page index and a byte within that page. The page index picks one entry from the page list of the chosen packet, and that list comes from an external page allocator.

When the area bit is 0, the window covers the outgoing packet that is being assembled. The same window also serves to read that packet's completion record after it has been sent. When the area bit is 1, the window covers the oldest received packet that the host has not yet consumed, which is the head of the receive queue. After each completed access the pointer can advance by the width of that access. When the buffer cannot serve the host in the current cycle, the block holds the access off by pulling its ready output low. In local-bus mode it never does this.

Top module: `pkt_window_ptr`

## Requirements
- R1: After reset `ptr_off` is 0, `ptr_area` is 0 and `ptr_inc` is 0. A cycle with `ptr_wr` high loads `ptr_wr_off`, `ptr_wr_area` and `ptr_wr_inc`, and the new values are visible after the next rising clock edge.
- R2: For a byte access, `ram_addr` is {page, byte}, where byte is `ptr_off[7:0]` and page is entry `ptr_off[10:8]` of the selected page list. Entry k of a list occupies bits [5k+4:5k].
- R3: `ptr_area` = 0 selects `tx_page_list`, and `ptr_area` = 1 selects `rx_page_list`.
- R4: When `ptr_inc` is 1, each completed access (`acc_req` and `acc_ready` both high at a clock edge) advances `ptr_off` by 1 for a byte access and by 2 for a 16-bit access (`acc_wide` = 1). The pointer does not move while an access waits, and it does not move when `ptr_inc` is 0.
- R5: A 16-bit access forces bit 0 of the byte-in-page address to 0 and drives `ram_wide` high.
- R6: A loaded or advanced offset at or above 1536 (six pages of 256 bytes) is held at exactly 1536, and `ptr_oor` reads 1. While `ptr_oor` is 1, accesses never raise `ram_en`, `acc_rdata` is 0 and `acc_ready` is 1.
- R7: With `ptr_area` = 0 and `tx_alloc` = 0, accesses are dropped. Writes raise neither `ram_en` nor `ram_we`, reads return 0, and `acc_ready` is 1.
- R8: With `local_bus` = 0 and `ram_grant` = 0, a pending valid access sees `acc_ready` = 0 and `ram_en` = 0. With `local_bus` = 1, `acc_ready` stays 1 and the access is issued whatever the state of `ram_grant`.
- R9: During an issued read, `acc_rdata` equals `ram_rdata`. `ram_we` is high only for an issued write, and `ram_wdata` carries `acc_wdata`.
- R10: When `ptr_wr` and a completed auto-advancing access fall in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_bus | input | 1 | Local-bus mode: never stretch the host access |
| ptr_wr | input | 1 | Load the pointer register |
| ptr_wr_area | input | 1 | Area bit to load (0 outgoing, 1 receive head) |
| ptr_wr_inc | input | 1 | Auto-advance enable to load |
| ptr_wr_off | input | 11 | Byte offset to load |
| acc_req | input | 1 | Host data access pending |
| acc_write | input | 1 | 1 write, 0 read |
| acc_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data |
| acc_ready | output | 1 | Access may complete this cycle |
| tx_alloc | input | 1 | An outgoing packet is allocated |
| tx_page_list | input | 30 | Six 5-bit page numbers of the outgoing packet |
| rx_page_list | input | 30 | Six 5-bit page numbers of the receive queue head |
| ram_grant | input | 1 | Buffer bandwidth available to the host |
| ram_en | output | 1 | Buffer access strobe |
| ram_we | output | 1 | Buffer write strobe |
| ram_wide | output | 1 | Buffer access is 16 bits |
| ram_addr | output | 13 | Physical buffer byte address |
| ram_wdata | output | 16 | Buffer write data |
| ram_rdata | input | 16 | Buffer read data |
| ptr_off | output | 11 | Current pointer offset |
| ptr_area | output | 1 | Current area bit |
| ptr_inc | output | 1 | Current auto-advance enable |
| ptr_oor | output | 1 | Offset is clamped out of range |

## Verification
The bench drives the mapping with offsets in the first page, in the last page, and at the last byte of a page followed by an auto-advance into the next page. These cases tell a correct page-index split apart from an off-by-one page selection or a wrong byte field. It uses the same offsets with both area values and with distinct page lists, so that a swapped list or a list ignored by the area bit becomes visible. Byte and 16-bit accesses at odd offsets separate the +1 step from the +2 step and expose a missing alignment. Stalled, granted and local-bus accesses show whether the advance is tied to completion or to the request. Offsets pushed past six pages and an empty outgoing area show whether dropped accesses ever reach the buffer.

// File: rtl/pkt_window_ptr.sv
module pkt_window_ptr #(
  parameter int MAX_PAGES = 6,
  parameter int PAGE_W    = 8,
  parameter int PGN_W     = 5,
  parameter int DATA_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       local_bus,
  input  logic                       ptr_wr,
  input  logic                       ptr_wr_area,
  input  logic                       ptr_wr_inc,
  input  logic [$clog2((MAX_PAGES<<PAGE_W)+1)-1:0] ptr_wr_off,
  input  logic                       acc_req,
  input  logic                       acc_write,
  input  logic                       acc_wide,
  input  logic [DATA_W-1:0]          acc_wdata,
  output logic [DATA_W-1:0]          acc_rdata,
  output logic                       acc_ready,
  input  logic                       tx_alloc,
  input  logic [MAX_PAGES*PGN_W-1:0] tx_page_list,
  input  logic [MAX_PAGES*PGN_W-1:0] rx_page_list,
  input  logic                       ram_grant,
  output logic                       ram_en,
  output logic                       ram_we,
  output logic                       ram_wide,
  output logic [PGN_W+PAGE_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  input  logic [DATA_W-1:0]          ram_rdata,
  output logic [$clog2((MAX_PAGES<<PAGE_W)+1)-1:0] ptr_off,
  output logic                       ptr_area,
  output logic                       ptr_inc,
  output logic                       ptr_oor
);
  localparam int LIMIT    = MAX_PAGES << PAGE_W;
  localparam int OFF_W    = $clog2(LIMIT + 1);
  localparam int IDX_W    = OFF_W - PAGE_W;
  localparam int SLOTS    = 1 << IDX_W;
  localparam logic [OFF_W:0]   LIM_X = LIMIT;
  localparam logic [OFF_W-1:0] LIM_O = LIMIT;
  localparam logic [OFF_W:0]   STEP1 = 1;
  localparam logic [OFF_W:0]   STEP2 = 2;

  logic [PGN_W-1:0] tx_pg [SLOTS];
  logic [PGN_W-1:0] rx_pg [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
    if (k < MAX_PAGES) begin : g_used
      assign tx_pg[k] = tx_page_list[k*PGN_W +: PGN_W];
      assign rx_pg[k] = rx_page_list[k*PGN_W +: PGN_W];
    end else begin : g_spare
      assign tx_pg[k] = '0;
      assign rx_pg[k] = '0;
    end
  end

  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] byte_sel;
  logic [PGN_W-1:0]  page;
  logic              drop, done;
  logic [OFF_W:0]    sum, load_x;

  assign idx      = ptr_off[OFF_W-1:PAGE_W];
  assign byte_sel = acc_wide ? {ptr_off[PAGE_W-1:1], 1'b0} : ptr_off[PAGE_W-1:0];
  assign page     = ptr_area ? rx_pg[idx] : tx_pg[idx];
  assign ptr_oor  = (ptr_off == LIM_O);

  assign drop      = ptr_oor | (~ptr_area & ~tx_alloc);
  assign acc_ready = drop | local_bus | ram_grant;
  assign ram_en    = acc_req & ~drop & (local_bus | ram_grant);
  assign ram_we    = ram_en & acc_write;
  assign ram_wide  = acc_wide;
  assign ram_addr  = {page, byte_sel};
  assign ram_wdata = acc_wdata;
  assign acc_rdata = (ram_en & ~acc_write) ? ram_rdata : '0;
  assign done      = acc_req & acc_ready;

  assign sum    = {1'b0, ptr_off} + (acc_wide ? STEP2 : STEP1);
  assign load_x = {1'b0, ptr_wr_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_off  <= '0;
      ptr_area <= 1'b0;
      ptr_inc  <= 1'b0;
    end else if (ptr_wr) begin
      ptr_off  <= (load_x >= LIM_X) ? LIM_O : ptr_wr_off;
      ptr_area <= ptr_wr_area;
      ptr_inc  <= ptr_wr_inc;
    end else if (done && ptr_inc) begin
      ptr_off  <= (sum >= LIM_X) ? LIM_O : sum[OFF_W-1:0];
    end
  end

  a_r6_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_off <= LIM_O);

  a_r6_no_ram_oor: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_oor |-> (!ram_en && acc_ready && acc_rdata == '0));

  a_r7_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !ptr_area && !tx_alloc) |-> (!ram_en && !ram_we && acc_ready));

  a_r8_local_ready: assert property (@(posedge clk) disable iff (!rst_n)
    local_bus |-> acc_ready);

  a_r8_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ready) |-> !ram_en);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ready && ptr_inc && !ptr_wr && !ptr_oor) |=>
      (ptr_oor || {1'b0, ptr_off} == {1'b0, $past(ptr_off)} + ($past(acc_wide) ? STEP2 : STEP1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !(acc_req && acc_ready)) |=> $stable(ptr_off));

  a_r9_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && acc_write));
endmodule

// File: tb/test_pkt_window_ptr.sv
module test_pkt_window_ptr;
  logic        clk = 0, rst_n = 0;
  logic        local_bus = 0, ptr_wr = 0, ptr_wr_area = 0, ptr_wr_inc = 0;
  logic [10:0] ptr_wr_off = 0;
  logic        acc_req = 0, acc_write = 0, acc_wide = 0;
  logic [15:0] acc_wdata = 0, acc_rdata;
  logic        acc_ready, tx_alloc = 1, ram_grant = 1;
  logic [29:0] tx_page_list, rx_page_list;
  logic        ram_en, ram_we, ram_wide;
  logic [12:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic [10:0] ptr_off;
  logic        ptr_area, ptr_inc, ptr_oor;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign ram_rdata = {3'b0, ram_addr} ^ 16'hA5A5;

  pkt_window_ptr i_pkt_window_ptr (.*);

  function automatic logic [4:0] txp(int k); return 5'(3 + k); endfunction
  function automatic logic [4:0] rxp(int k); return 5'(20 + k); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(logic area, logic inc, logic [10:0] off);
    @(negedge clk);
    ptr_wr = 1; ptr_wr_area = area; ptr_wr_inc = inc; ptr_wr_off = off;
    @(negedge clk);
    ptr_wr = 0;
  endtask

  task automatic t_reset;
    check("R1 reset off", ptr_off, 0);
    check("R1 reset area", ptr_area, 0);
    check("R1 reset inc", ptr_inc, 0);
    load(1, 1, 11'h155);
    check("R1 load off", ptr_off, 11'h155);
    check("R1 load area", ptr_area, 1);
    check("R1 load inc", ptr_inc, 1);
  endtask

  task automatic t_map;
    load(0, 0, 11'h123);
    acc_req = 1; acc_write = 0; acc_wide = 0; #1;
    check("R2 tx addr", ram_addr, {txp(1), 8'h23});
    check("R9 read data", acc_rdata, {3'b0, txp(1), 8'h23} ^ 16'hA5A5);
    check("R9 no write", ram_we, 0);
    @(negedge clk); acc_req = 0;
    load(1, 0, 11'h5FF);
    acc_req = 1; #1;
    check("R3 rx addr", ram_addr, {rxp(5), 8'hFF});
    load(0, 0, 11'h5FF); acc_req = 1; #1;
    check("R3 tx addr", ram_addr, {txp(5), 8'hFF});
    acc_write = 1; acc_wdata = 16'hBEEF; #1;
    check("R9 write strobe", ram_we, 1);
    check("R9 write data", ram_wdata, 16'hBEEF);
    @(negedge clk); acc_req = 0; acc_write = 0;
  endtask

  task automatic t_autoinc;
    load(0, 1, 11'h0FF);
    acc_req = 1; acc_write = 1; acc_wide = 0; #1;
    check("R2 last byte", ram_addr, {txp(0), 8'hFF});
    @(negedge clk);
    check("R4 byte step", ptr_off, 11'h100);
    #1;
    check("R2 next page", ram_addr, {txp(1), 8'h00});
    acc_wide = 1;
    @(negedge clk);
    check("R4 wide step", ptr_off, 11'h102);
    acc_req = 0; acc_wide = 0;
    load(0, 1, 11'h103);
    acc_req = 1; acc_wide = 1; #1;
    check("R5 align", ram_addr, {txp(1), 8'h02});
    check("R5 wide flag", ram_wide, 1);
    @(negedge clk); acc_req = 0; acc_wide = 0;
    check("R4 odd wide step", ptr_off, 11'h105);
    load(0, 0, 11'h040);
    acc_req = 1;
    @(negedge clk); acc_req = 0;
    check("R4 no inc", ptr_off, 11'h040);
    acc_write = 0;
  endtask

  task automatic t_wait;
    load(0, 1, 11'h010);
    ram_grant = 0; acc_req = 1; #1;
    check("R8 stall ready", acc_ready, 0);
    check("R8 stall en", ram_en, 0);
    @(negedge clk);
    check("R4 no move while wait", ptr_off, 11'h010);
    ram_grant = 1; #1;
    check("R8 granted", ram_en, 1);
    @(negedge clk); acc_req = 0;
    check("R4 after grant", ptr_off, 11'h011);
    local_bus = 1; ram_grant = 0; acc_req = 1; #1;
    check("R8 local ready", acc_ready, 1);
    check("R8 local en", ram_en, 1);
    @(negedge clk); acc_req = 0; local_bus = 0; ram_grant = 1;
  endtask

  task automatic t_clamp;
    load(0, 1, 11'h7FF);
    check("R6 load clamp", ptr_off, 11'd1536);
    check("R6 flag", ptr_oor, 1);
    acc_req = 1; acc_write = 1; #1;
    check("R6 no ram", ram_en, 0);
    check("R6 ready", acc_ready, 1);
    acc_write = 0; #1;
    check("R6 read zero", acc_rdata, 0);
    @(negedge clk); acc_req = 0;
    load(1, 1, 11'h5FE);
    check("R6 in range", ptr_oor, 0);
    acc_req = 1; acc_wide = 1;
    @(negedge clk); acc_req = 0; acc_wide = 0;
    check("R6 inc clamp", ptr_off, 11'd1536);
    check("R6 inc flag", ptr_oor, 1);
  endtask

  task automatic t_txempty;
    tx_alloc = 0;
    load(0, 0, 11'h020);
    acc_req = 1; acc_write = 1; #1;
    check("R7 no en", ram_en, 0);
    check("R7 no we", ram_we, 0);
    check("R7 ready", acc_ready, 1);
    acc_write = 0; #1;
    check("R7 read zero", acc_rdata, 0);
    @(negedge clk); acc_req = 0;
    load(1, 0, 11'h020);
    acc_req = 1; #1;
    check("R7 rx unaffected", ram_en, 1);
    @(negedge clk); acc_req = 0; tx_alloc = 1;
  endtask

  task automatic t_loadwins;
    load(0, 1, 11'h030);
    @(negedge clk);
    acc_req = 1; ptr_wr = 1; ptr_wr_area = 0; ptr_wr_inc = 1; ptr_wr_off = 11'h200;
    @(negedge clk);
    acc_req = 0; ptr_wr = 0;
    check("R10 load wins", ptr_off, 11'h200);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin
      tx_page_list[k*5 +: 5] = txp(k);
      rx_page_list[k*5 +: 5] = rxp(k);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_map;
    t_autoinc;
    t_wait;
    t_clamp;
    t_txempty;
    t_loadwins;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule